// File: doc/BRIEF.md
# Banked Data Register File

This block is the 8-bit data memory behind a small microcontroller core. The core presents a 7-bit direct address and a bank-select bit. Together they form an 8-bit effective address that covers two banks of 128 locations. The low slots of each bank are special-function registers. Most of these live in peripherals outside the block and are reached through a dedicated SFR port. The block holds one SFR itself: the indirection pointer. The slots above the SFR area are general-purpose RAM, shared by both banks. The top of each bank and one SFR slot are empty.

Slot zero of either bank is virtual. An access there is redirected to the 8-bit effective address held in the pointer. This reaches either bank without regard to the bank-select bit. Writes land on the rising clock edge. Reads are combinational, so a value written in one cycle is visible in the next.

Top module: `bankrf_top`

## Requirements
- R1: A direct access uses effective address {bankSel, addr}. For the bank-specific SFR slots 01h, 05h, 06h, 08h and 09h, `sfrAddr` presents that address unchanged, so 05h and 85h are distinct.
- R2: A write to RAM at 0Ch-4Fh stores `wrData` at the clock edge, and a read in the next cycle returns it combinationally.
- R3: Effective addresses 8Ch-CFh reach the same RAM bytes as 0Ch-4Fh.
- R4: Addresses 07h, 87h, 50h-7Fh and D0h-FFh read as 00h. A write to them changes no RAM byte and does not raise `sfrWrEn`.
- R5: An access at direct offset 00h, in either bank, is performed at the effective address held in `ptr`, whatever `bankSel` is. This covers RAM, SFR and empty locations.
- R6: The pointer sits at offset 04h of both banks and is output on `ptr`. Reset clears it to 00h. A write takes effect at the clock edge.
- R7: When `ptr` is 00h or 80h, an indirect access reads 00h, and a write through it changes nothing and does not raise `sfrWrEn`.
- R8: SFR slots 02h, 03h, 0Ah and 0Bh are shared by both banks: `sfrAddr` shows them with bit 7 cleared even when reached from bank 1.
- R9: An access to an external SFR returns `sfrRdData`. A write to one raises `sfrWrEn` for that cycle, with `wrData` on `sfrWrData`. No other access raises `sfrWrEn`.
- R10: An indirect write whose pointer targets the pointer slot (04h or 84h) loads the pointer itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset |
| bankSel | input | 1 | Bank chosen for direct accesses |
| addr | input | 7 | Direct address within the bank |
| wrEn | input | 1 | Write strobe; low means read |
| wrData | input | 8 | Data to write |
| rdData | output | 8 | Combinational read data |
| sfrAddr | output | 8 | Effective SFR address, shared slots folded to bank 0 |
| sfrWrEn | output | 1 | Write strobe to the external SFRs |
| sfrWrData | output | 8 | Write data to the external SFRs |
| sfrRdData | input | 8 | Read data from the external SFRs |
| ptr | output | 8 | Current indirection pointer |

## Verification
Address resolution through the pointer and an update of the pointer itself can fall in the same cycle. This happens when an indirect write targets the pointer slot. It is provoked by loading 84h into the pointer and then writing through offset 00h from bank 1. The access must return the old pointer in that cycle and leave the written value on `ptr` after the edge, with `sfrWrEn` low throughout. A null-pointer write is also judged by reading the pointer back, which confirms it was left unchanged.

// File: rtl/bankrf_pkg.sv
package bankrf_pkg;

  typedef enum logic [1:0] {
    RD_ZERO = 2'd0,
    RD_RAM  = 2'd1,
    RD_PTR  = 2'd2,
    RD_SFR  = 2'd3
  } rdSel_e;

  // Strobes from address control to the datapath
  typedef struct packed {
    logic   ramWe;
    logic   ptrWe;
    logic   sfrWe;
    rdSel_e rdSel;
  } strobe_t;

endpackage

// File: rtl/bankrf_ctrl.sv
module bankrf_ctrl
  import bankrf_pkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int RAM_BASE    = 12,
  parameter int RAM_TOP     = 79,
  parameter int RAM_IDX_W   = 7,
  parameter int SFR_SLOTS   = 12,
  parameter int PTR_OFF     = 4,
  parameter int HOLE_OFF    = 7,
  parameter logic [SFR_SLOTS-1:0] MIRROR_MASK = '0
) (
  input  logic                 bankSel,
  input  logic [ADDR_W-1:0]    addr,
  input  logic                 wrEn,
  input  logic [ADDR_W:0]      ptr,
  output strobe_t              stb,
  output logic [ADDR_W:0]      sfrAddr,
  output logic [RAM_IDX_W-1:0] ramIdx
);

  localparam int SLOT_W = $clog2(SFR_SLOTS);
  localparam logic [ADDR_W-1:0] SFR_END  = ADDR_W'(SFR_SLOTS);
  localparam logic [ADDR_W-1:0] RAM_LO   = ADDR_W'(RAM_BASE);
  localparam logic [ADDR_W-1:0] RAM_HI   = ADDR_W'(RAM_TOP);
  localparam logic [ADDR_W-1:0] PTR_SLOT = ADDR_W'(PTR_OFF);
  localparam logic [ADDR_W-1:0] HOLE     = ADDR_W'(HOLE_OFF);

  logic              isIndir;
  logic [ADDR_W:0]   effAddr;
  logic [ADDR_W-1:0] offset;
  logic [ADDR_W-1:0] ramOff;

  assign isIndir = (addr == '0);
  assign effAddr = isIndir ? ptr : {bankSel, addr};
  assign offset  = effAddr[ADDR_W-1:0];
  assign ramOff  = offset - RAM_LO;
  assign ramIdx  = ramOff[RAM_IDX_W-1:0];

  always_comb begin
    stb       = '0;
    stb.rdSel = RD_ZERO;
    sfrAddr   = effAddr;
    if (offset == '0) begin
      // null pointer: no target
      stb.rdSel = RD_ZERO;
    end else if (offset < SFR_END) begin
      if (MIRROR_MASK[offset[SLOT_W-1:0]]) sfrAddr[ADDR_W] = 1'b0;
      if (offset == HOLE) begin
        stb.rdSel = RD_ZERO;
      end else if (offset == PTR_SLOT) begin
        stb.rdSel = RD_PTR;
        stb.ptrWe = wrEn;
      end else begin
        stb.rdSel = RD_SFR;
        stb.sfrWe = wrEn;
      end
    end else if (offset <= RAM_HI) begin
      stb.rdSel = RD_RAM;
      stb.ramWe = wrEn;
    end
  end

endmodule

// File: rtl/bankrf_dp.sv
module bankrf_dp
  import bankrf_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int RAM_BYTES = 68,
  parameter int RAM_IDX_W = 7
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strobe_t              stb,
  input  logic [RAM_IDX_W-1:0] ramIdx,
  input  logic [DATA_W-1:0]    wrData,
  input  logic [DATA_W-1:0]    sfrRdData,
  output logic [DATA_W-1:0]    rdData,
  output logic [DATA_W-1:0]    ptr
);

  logic [DATA_W-1:0] mem [RAM_BYTES];

  always_ff @(posedge clk) begin
    if (stb.ramWe) mem[ramIdx] <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          ptr <= '0;
    else if (stb.ptrWe) ptr <= wrData;
  end

  always_comb begin
    unique case (stb.rdSel)
      RD_RAM:  rdData = mem[ramIdx];
      RD_PTR:  rdData = ptr;
      RD_SFR:  rdData = sfrRdData;
      default: rdData = '0;
    endcase
  end

endmodule

// File: rtl/bankrf_top.sv
module bankrf_top
  import bankrf_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int RAM_BASE  = 12,
  parameter int RAM_BYTES = 68,
  parameter int SFR_SLOTS = 12,
  parameter int PTR_OFF   = 4,
  parameter int HOLE_OFF  = 7,
  parameter logic [SFR_SLOTS-1:0] MIRROR_MASK = 12'hC1C
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bankSel,
  input  logic [DATA_W-2:0] addr,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] sfrAddr,
  output logic              sfrWrEn,
  output logic [DATA_W-1:0] sfrWrData,
  input  logic [DATA_W-1:0] sfrRdData,
  output logic [DATA_W-1:0] ptr
);

  localparam int ADDR_W    = DATA_W - 1;
  localparam int RAM_TOP   = RAM_BASE + RAM_BYTES - 1;
  localparam int RAM_IDX_W = $clog2(RAM_BYTES);

  strobe_t              stb;
  logic [RAM_IDX_W-1:0] ramIdx;

  bankrf_ctrl #(
    .ADDR_W(ADDR_W), .RAM_BASE(RAM_BASE), .RAM_TOP(RAM_TOP),
    .RAM_IDX_W(RAM_IDX_W), .SFR_SLOTS(SFR_SLOTS), .PTR_OFF(PTR_OFF),
    .HOLE_OFF(HOLE_OFF), .MIRROR_MASK(MIRROR_MASK)
  ) u_ctrl (
    .bankSel(bankSel), .addr(addr), .wrEn(wrEn), .ptr(ptr),
    .stb(stb), .sfrAddr(sfrAddr), .ramIdx(ramIdx)
  );

  bankrf_dp #(
    .DATA_W(DATA_W), .RAM_BYTES(RAM_BYTES), .RAM_IDX_W(RAM_IDX_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .ramIdx(ramIdx), .wrData(wrData),
    .sfrRdData(sfrRdData), .rdData(rdData), .ptr(ptr)
  );

  assign sfrWrEn   = stb.sfrWe;
  assign sfrWrData = wrData;

endmodule

// File: rtl/bankrf_chk.sv
module bankrf_chk (
  input logic       clk,
  input logic       rstN,
  input logic       bankSel,
  input logic [6:0] addr,
  input logic       wrEn,
  input logic [7:0] wrData,
  input logic [7:0] rdData,
  input logic [7:0] sfrAddr,
  input logic       sfrWrEn,
  input logic [7:0] sfrWrData,
  input logic [7:0] ptr
);

  AST_HOLE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (addr == 7'h07 || addr >= 7'h50) |-> (rdData == 8'h00 && !sfrWrEn)); // R4

  AST_PTR_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == 7'h04) |=> (ptr == $past(wrData))); // R6

  AST_NULL_PTR_READ: assert property (@(posedge clk) disable iff (!rstN)
    (addr == 7'h00 && ptr[6:0] == 7'h00) |-> (rdData == 8'h00 && !sfrWrEn)); // R7

  AST_NULL_PTR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == 7'h00 && ptr[6:0] == 7'h00) |=> $stable(ptr)); // R7

  AST_SFR_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    sfrWrEn |-> (wrEn && sfrWrData == wrData)); // R9

  AST_MIRROR_FOLD: assert property (@(posedge clk) disable iff (!rstN)
    (addr == 7'h02 || addr == 7'h03 || addr == 7'h0A || addr == 7'h0B) |-> !sfrAddr[7]); // R8

  AST_DIRECT_SFR_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    (addr == 7'h01 || addr == 7'h05 || addr == 7'h06 || addr == 7'h08 || addr == 7'h09)
      |-> (sfrAddr == {bankSel, addr})); // R1

endmodule

bind bankrf_top bankrf_chk u_chk (
  .clk(clk), .rstN(rstN), .bankSel(bankSel), .addr(addr), .wrEn(wrEn),
  .wrData(wrData), .rdData(rdData), .sfrAddr(sfrAddr), .sfrWrEn(sfrWrEn),
  .sfrWrData(sfrWrData), .ptr(ptr)
);

// File: tb/tb_bankrf_top.sv
module tb_bankrf_top;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       bankSel = 1'b0;
  logic [6:0] addr = '0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData, sfrAddr, sfrWrData, sfrRdData, ptr;
  logic       sfrWrEn;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // Peripheral model: each external SFR reads as its address xor 5Ah
  assign sfrRdData = sfrAddr ^ 8'h5A;

  bankrf_top dut (
    .clk(clk), .rstN(rstN), .bankSel(bankSel), .addr(addr), .wrEn(wrEn),
    .wrData(wrData), .rdData(rdData), .sfrAddr(sfrAddr), .sfrWrEn(sfrWrEn),
    .sfrWrData(sfrWrData), .sfrRdData(sfrRdData), .ptr(ptr)
  );

  typedef struct packed {
    logic       bank;
    logic [6:0] a;
    logic       wr;
    logic [7:0] wd;
    logic       chkRd;
    logic [7:0] expRd;
    logic       expWe;
    logic       chkSa;
    logic [7:0] expSa;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 31;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 7'h0C, 1'b1, 8'h11, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 4'd2},  // R2 write 0Ch
    '{1'b0, 7'h0C, 1'b0, 8'h00, 1'b1, 8'h11, 1'b0, 1'b0, 8'h00, 4'd2},  // R2 read back
    '{1'b1, 7'h0C, 1'b0, 8'h00, 1'b1, 8'h11, 1'b0, 1'b0, 8'h00, 4'd3},  // R3 8Ch alias
    '{1'b1, 7'h4F, 1'b1, 8'h22, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 4'd3},  // R3 write CFh
    '{1'b0, 7'h4F, 1'b0, 8'h00, 1'b1, 8'h22, 1'b0, 1'b0, 8'h00, 4'd3},  // R3 read 4Fh
    '{1'b0, 7'h50, 1'b1, 8'h33, 1'b1, 8'h00, 1'b0, 1'b0, 8'h00, 4'd4},  // R4 hole 50h
    '{1'b0, 7'h50, 1'b0, 8'h00, 1'b1, 8'h00, 1'b0, 1'b0, 8'h00, 4'd4},  // R4
    '{1'b1, 7'h07, 1'b1, 8'h44, 1'b1, 8'h00, 1'b0, 1'b0, 8'h00, 4'd4},  // R4 hole 87h
    '{1'b1, 7'h7F, 1'b1, 8'h45, 1'b1, 8'h00, 1'b0, 1'b0, 8'h00, 4'd4},  // R4 hole FFh
    '{1'b0, 7'h05, 1'b1, 8'h66, 1'b1, 8'h5F, 1'b1, 1'b1, 8'h05, 4'd1},  // R1 05h
    '{1'b1, 7'h05, 1'b1, 8'h77, 1'b1, 8'hDF, 1'b1, 1'b1, 8'h85, 4'd1},  // R1 85h
    '{1'b1, 7'h03, 1'b0, 8'h00, 1'b1, 8'h59, 1'b0, 1'b1, 8'h03, 4'd8},  // R8 83h folds
    '{1'b1, 7'h0B, 1'b1, 8'h13, 1'b1, 8'h51, 1'b1, 1'b1, 8'h0B, 4'd8},  // R8 8Bh folds
    '{1'b1, 7'h00, 1'b0, 8'h00, 1'b1, 8'h00, 1'b0, 1'b0, 8'h00, 4'd7},  // R7 ptr 00h
    '{1'b1, 7'h00, 1'b1, 8'h55, 1'b1, 8'h00, 1'b0, 1'b0, 8'h00, 4'd7},  // R7 write null
    '{1'b1, 7'h04, 1'b1, 8'h0C, 1'b1, 8'h00, 1'b0, 1'b0, 8'h00, 4'd6},  // R6 load ptr
    '{1'b0, 7'h04, 1'b0, 8'h00, 1'b1, 8'h0C, 1'b0, 1'b0, 8'h00, 4'd6},  // R6 shared slot
    '{1'b1, 7'h00, 1'b0, 8'h00, 1'b1, 8'h11, 1'b0, 1'b0, 8'h00, 4'd5},  // R5 via ptr
    '{1'b1, 7'h00, 1'b1, 8'h99, 1'b1, 8'h11, 1'b0, 1'b0, 8'h00, 4'd5},  // R5 write via ptr
    '{1'b0, 7'h0C, 1'b0, 8'h00, 1'b1, 8'h99, 1'b0, 1'b0, 8'h00, 4'd5},  // R5 landed
    '{1'b0, 7'h04, 1'b1, 8'h85, 1'b1, 8'h0C, 1'b0, 1'b0, 8'h00, 4'd6},  // R6 ptr=85h
    '{1'b0, 7'h00, 1'b0, 8'h00, 1'b1, 8'hDF, 1'b0, 1'b1, 8'h85, 4'd5},  // R5 bank 1 SFR
    '{1'b0, 7'h00, 1'b1, 8'h12, 1'b1, 8'hDF, 1'b1, 1'b1, 8'h85, 4'd9},  // R9 indirect SFR write
    '{1'b0, 7'h04, 1'b1, 8'h84, 1'b1, 8'h85, 1'b0, 1'b0, 8'h00, 4'd6},  // R6 ptr=84h
    '{1'b1, 7'h00, 1'b1, 8'h20, 1'b1, 8'h84, 1'b0, 1'b0, 8'h00, 4'd10}, // R10 self target
    '{1'b0, 7'h04, 1'b0, 8'h00, 1'b1, 8'h20, 1'b0, 1'b0, 8'h00, 4'd10}, // R10 loaded
    '{1'b0, 7'h04, 1'b1, 8'h80, 1'b1, 8'h20, 1'b0, 1'b0, 8'h00, 4'd6},  // R6 ptr=80h
    '{1'b0, 7'h00, 1'b1, 8'h77, 1'b1, 8'h00, 1'b0, 1'b0, 8'h00, 4'd7},  // R7 null 80h
    '{1'b0, 7'h04, 1'b0, 8'h00, 1'b1, 8'h80, 1'b0, 1'b0, 8'h00, 4'd7},  // R7 ptr kept
    '{1'b0, 7'h4F, 1'b0, 8'h00, 1'b1, 8'h22, 1'b0, 1'b0, 8'h00, 4'd4},  // R4 RAM untouched
    '{1'b0, 7'h0C, 1'b0, 8'h00, 1'b1, 8'h99, 1'b0, 1'b0, 8'h00, 4'd4}   // R4 RAM untouched
  };

  task automatic check8(input string what, input int req, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL R%0d %s: actual %02h expected %02h", req, what, act, exp);
    end
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL R0 watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin : stim
    repeat (2) @(negedge clk);
    // Reset state: pointer reads 00h on the port and through both slots (R6)
    #1;
    check8("reset ptr", 6, ptr, 8'h00);
    rstN = 1'b1;
    @(negedge clk);
    bankSel = 1'b0; addr = 7'h04; wrEn = 1'b0;
    #1 check8("reset ptr via 04h", 6, rdData, 8'h00);
    @(negedge clk);
    bankSel = 1'b1; addr = 7'h04;
    #1 check8("reset ptr via 84h", 6, rdData, 8'h00);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      bankSel = VEC[i].bank; addr = VEC[i].a; wrEn = VEC[i].wr; wrData = VEC[i].wd;
      #1;
      if (VEC[i].chkRd) check8($sformatf("vec %0d rdData", i), int'(VEC[i].req), rdData, VEC[i].expRd);
      check8($sformatf("vec %0d sfrWrEn", i), int'(VEC[i].req), {7'd0, sfrWrEn}, {7'd0, VEC[i].expWe});
      if (VEC[i].chkSa) check8($sformatf("vec %0d sfrAddr", i), int'(VEC[i].req), sfrAddr, VEC[i].expSa);
      if (VEC[i].expWe) check8($sformatf("vec %0d sfrWrData", i), 9, sfrWrData, VEC[i].wd);
    end

    // R10: after the self-targeting write and later loads, ptr port agrees
    @(negedge clk);
    wrEn = 1'b0; addr = 7'h0A; bankSel = 1'b1;
    #1;
    check8("ptr port after null write", 7, ptr, 8'h80);
    check8("0Ah shared slot fold", 8, sfrAddr, 8'h0A);
    check8("0Ah read", 9, rdData, 8'h0A ^ 8'h5A);

    // R6: reset mid-run clears the pointer
    @(negedge clk);
    rstN = 1'b0;
    #1 check8("reset mid-run", 6, ptr, 8'h00);
    @(negedge clk);
    rstN = 1'b1;

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule